// File: doc/BRIEF.md
# Turn-Model Mesh Route Computation

This block computes the output direction for a packet entering a router of a two-dimensional mesh. It receives the destination coordinates carried by a head flit and the router's own coordinates. It also receives a free-space hint for each of the four neighbouring outputs. From these it produces a one-hot request for one output: East, West, North, South or the Local ejection port. A static mode input selects one of four deadlock-free turn models. The first is fixed dimension order (X then Y). The other three are adaptive variants: west-first, north-last and negative-first.

In the adaptive modes, some destinations leave both an X and a Y direction that are legal and that move the packet closer. The block then picks the direction whose downstream hint reports more free space. A tie goes to the X direction. Routing is always minimal, so a direction that does not move the packet closer is never requested.

The head side is a valid/ready stream. A head is accepted on a cycle where both `hd_valid` and `hd_ready` are high. The route is computed from the mode, coordinates and hints present on that cycle and is registered. The result is then held on the route side as a valid/ready stream until the consumer releases it by raising `route_ready` while `route_valid` is high. While a route is held, `hd_ready` stays low, so the upstream side is back-pressured for the whole life of the packet. Inputs that change during that time have no effect on the held result.

Top module: `rc_turn_route`

## Requirements
- R1: While reset is active and after it ends with no head offered, `route_valid` is 0, `route_port` is 0 and `hd_ready` is 1.
- R2: A head accepted at a clock edge makes `route_valid` 1 from that edge on, with `route_port` exactly one-hot. Whenever `route_valid` is 0, `route_port` is 0. The bits of `route_port` are: bit 0 East (+X), bit 1 West (−X), bit 2 North (+Y), bit 3 South (−Y), bit 4 Local.
- R3: While `route_valid` is 1 and `route_ready` is 0, `route_port` stays unchanged, `route_valid` stays 1 and `hd_ready` is 0.
- R4: At the edge where `route_valid` and `route_ready` are both 1, the route is released. After that edge, `route_valid` is 0 and `hd_ready` is 1.
- R5: When the destination equals the local coordinates, Local (bit 4) is requested in every mode.
- R6: In mode 0 (dimension order), East or West is requested while the destination X differs from the local X. North or South is requested only once the X coordinates match.
- R7: In mode 1 (west-first), West is requested whenever the destination X is smaller than the local X, whatever the hints. Otherwise the block chooses adaptively among the productive East, North and South directions.
- R8: In mode 2 (north-last), North is requested only when it is the sole productive direction. Otherwise the block chooses among the productive East, West and South directions.
- R9: In mode 3 (negative-first), West or South is requested while either is productive. East or North is requested only once neither is productive.
- R10: The requested direction always reduces the distance to the destination. East requires destination X greater than local X, West requires it smaller, North requires destination Y greater, South requires it smaller.
- R11: When an adaptive mode leaves one legal X direction and one legal Y direction, the block picks the one with the larger hint. On equal hints it picks the X direction. `hint` carries four unsigned fields of `HINT_W` bits: East at the lowest field, then West, North and South.
- R12: The mode, coordinates and hints are sampled only on the accepting cycle. A different head offered while a route is held is taken only after release, and it is routed from its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Turn model: 0 dimension order, 1 west-first, 2 north-last, 3 negative-first |
| my_x | input | X_W | Local node X coordinate |
| my_y | input | Y_W | Local node Y coordinate |
| hint | input | 4*HINT_W | Free-space hint per direction (E, W, N, S from the low field up) |
| hd_valid | input | 1 | Head flit destination offered |
| hd_ready | output | 1 | Head can be accepted (no route held) |
| hd_dst_x | input | X_W | Destination X of the head flit |
| hd_dst_y | input | Y_W | Destination Y of the head flit |
| route_valid | output | 1 | A route is held for the current packet |
| route_ready | input | 1 | Consumer releases the held route |
| route_port | output | 5 | One-hot output request, zero when no route is held |

## Verification
The route has one register of latency. It appears on `route_port` from the clock edge that accepts the head. The bench therefore drives each head half a cycle before that edge and reads the result half a cycle after it. A release takes effect at the edge where `route_ready` is seen high, so the bench checks `route_valid` and `hd_ready` on the falling edge that follows. The back-pressure test holds a route for several cycles while changing every input, checks the held value on each falling edge, and then checks that the waiting head is routed one edge after `hd_ready` returns.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [1:0] {
    RC_DOR        = 2'd0,
    RC_WEST_FIRST = 2'd1,
    RC_NORTH_LAST = 2'd2,
    RC_NEG_FIRST  = 2'd3
  } rc_mode_e;

  localparam int P_E = 0;
  localparam int P_W = 1;
  localparam int P_N = 2;
  localparam int P_S = 3;
  localparam int P_L = 4;

  localparam int NUM_DIRS  = 4;
  localparam int NUM_PORTS = NUM_DIRS + 1;

endpackage

// File: rtl/rc_productive.sv
module rc_productive
  import rc_pkg::*;
#(
  parameter int X_W = 4,
  parameter int Y_W = 4
) (
  input  logic [X_W-1:0]      cur_x,
  input  logic [Y_W-1:0]      cur_y,
  input  logic [X_W-1:0]      dst_x,
  input  logic [Y_W-1:0]      dst_y,
  output logic [NUM_DIRS-1:0] need
);

  always_comb begin
    need      = '0;
    need[P_E] = dst_x > cur_x;
    need[P_W] = dst_x < cur_x;
    need[P_N] = dst_y > cur_y;
    need[P_S] = dst_y < cur_y;
  end

endmodule

// File: rtl/rc_turn_filter.sv
module rc_turn_filter
  import rc_pkg::*;
(
  input  rc_mode_e            mode,
  input  logic [NUM_DIRS-1:0] need,
  output logic [NUM_DIRS-1:0] legal
);

  logic need_x;
  logic need_neg;
  logic [NUM_DIRS-1:0] pos_mask;
  logic [NUM_DIRS-1:0] neg_mask;

  always_comb begin
    need_x   = need[P_E] | need[P_W];
    need_neg = need[P_W] | need[P_S];
    pos_mask = '0;
    pos_mask[P_E] = 1'b1;
    pos_mask[P_N] = 1'b1;
    neg_mask = ~pos_mask;
  end

  always_comb begin
    legal = '0;
    unique case (mode)
      RC_DOR: begin
        if (need_x) begin
          legal[P_E] = need[P_E];
          legal[P_W] = need[P_W];
        end else begin
          legal[P_N] = need[P_N];
          legal[P_S] = need[P_S];
        end
      end
      RC_WEST_FIRST: begin
        if (need[P_W]) legal[P_W] = 1'b1;
        else           legal = need;
      end
      RC_NORTH_LAST: begin
        legal = need;
        if (need[P_E] | need[P_W] | need[P_S]) legal[P_N] = 1'b0;
      end
      RC_NEG_FIRST: begin
        if (need_neg) legal = need & neg_mask;
        else          legal = need & pos_mask;
      end
      default: legal = '0;
    endcase
  end

endmodule

// File: rtl/rc_select.sv
module rc_select
  import rc_pkg::*;
#(
  parameter int HINT_W = 4
) (
  input  logic [NUM_DIRS-1:0]        legal,
  input  logic [NUM_DIRS*HINT_W-1:0] hint,
  output logic [NUM_PORTS-1:0]       port
);

  logic [HINT_W-1:0] free_q [NUM_DIRS];

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_unpack
    assign free_q[d] = hint[d*HINT_W +: HINT_W];
  end

  logic has_x, has_y;
  logic [HINT_W-1:0] fx, fy;
  logic pick_x;

  always_comb begin
    has_x  = legal[P_E] | legal[P_W];
    has_y  = legal[P_N] | legal[P_S];
    fx     = legal[P_E] ? free_q[P_E] : free_q[P_W];
    fy     = legal[P_N] ? free_q[P_N] : free_q[P_S];
    pick_x = has_x && (!has_y || (fx >= fy));
    port   = '0;
    if (pick_x) begin
      if (legal[P_E]) port[P_E] = 1'b1;
      else            port[P_W] = 1'b1;
    end else if (has_y) begin
      if (legal[P_N]) port[P_N] = 1'b1;
      else            port[P_S] = 1'b1;
    end else begin
      port[P_L] = 1'b1;
    end
  end

endmodule

// File: rtl/rc_turn_route.sv
module rc_turn_route
  import rc_pkg::*;
#(
  parameter int X_W    = 4,
  parameter int Y_W    = 4,
  parameter int HINT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  mode,
  input  logic [X_W-1:0]              my_x,
  input  logic [Y_W-1:0]              my_y,
  input  logic [NUM_DIRS*HINT_W-1:0]  hint,
  input  logic                        hd_valid,
  output logic                        hd_ready,
  input  logic [X_W-1:0]              hd_dst_x,
  input  logic [Y_W-1:0]              hd_dst_y,
  output logic                        route_valid,
  input  logic                        route_ready,
  output logic [NUM_PORTS-1:0]        route_port
);

  localparam logic [NUM_PORTS-1:0] LOCAL_ONEHOT = NUM_PORTS'(1) << P_L;

  logic [NUM_DIRS-1:0]  need;
  logic [NUM_DIRS-1:0]  legal;
  logic [NUM_PORTS-1:0] port_next;
  logic [NUM_PORTS-1:0] route_q;
  logic                 valid_q;
  logic                 accept;
  rc_mode_e             mode_e;

  assign mode_e = rc_mode_e'(mode);

  rc_productive #(.X_W(X_W), .Y_W(Y_W)) u_prod (
    .cur_x (my_x),
    .cur_y (my_y),
    .dst_x (hd_dst_x),
    .dst_y (hd_dst_y),
    .need  (need)
  );

  rc_turn_filter u_filt (
    .mode  (mode_e),
    .need  (need),
    .legal (legal)
  );

  rc_select #(.HINT_W(HINT_W)) u_sel (
    .legal (legal),
    .hint  (hint),
    .port  (port_next)
  );

  assign hd_ready = !valid_q;
  assign accept   = hd_valid && hd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      route_q <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      route_q <= port_next;
    end else if (valid_q && route_ready) begin
      valid_q <= 1'b0;
      route_q <= '0;
    end
  end

  assign route_valid = valid_q;
  assign route_port  = route_q;

  // R2: one-hot while held, zero while idle
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> $onehot(route_port));
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !route_valid |-> (route_port == '0));

  // R3: held result under back-pressure
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && !route_ready) |=> (route_valid && $stable(route_port)));

  // R4: release
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && route_ready) |=> !route_valid);

  // R5: local ejection
  p_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hd_dst_x == my_x && hd_dst_y == my_y) |=> (route_port == LOCAL_ONEHOT));

  // R6: dimension order resolves X first
  p_dor_x_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_e == RC_DOR && hd_dst_x != my_x) |=> (route_port[P_E] || route_port[P_W]));

  // R7: west-first
  p_west_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_e == RC_WEST_FIRST && hd_dst_x < my_x) |=> route_port[P_W]);

  // R8: north-last
  p_north_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_e == RC_NORTH_LAST && (hd_dst_x != my_x || hd_dst_y < my_y))
      |=> !route_port[P_N]);

  // R9: negative-first
  p_neg_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_e == RC_NEG_FIRST && (hd_dst_x < my_x || hd_dst_y < my_y))
      |=> (route_port[P_W] || route_port[P_S]));

  // R10: minimal routing
  p_minimal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((!route_port[P_E] || $past(hd_dst_x) > $past(my_x)) &&
                (!route_port[P_W] || $past(hd_dst_x) < $past(my_x)) &&
                (!route_port[P_N] || $past(hd_dst_y) > $past(my_y)) &&
                (!route_port[P_S] || $past(hd_dst_y) < $past(my_y))));

  // R10: the selector only picks a direction the turn filter allows
  p_pick_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hd_valid |-> ((port_next[NUM_DIRS-1:0] & ~legal) == '0));

endmodule

// File: tb/rc_turn_route_tb_top.sv
`timescale 1ns/1ps
module rc_turn_route_tb_top;

  localparam int X_W    = 4;
  localparam int Y_W    = 4;
  localparam int HINT_W = 4;
  localparam int HW     = 4 * HINT_W;

  localparam logic [4:0] PE = 5'b00001;
  localparam logic [4:0] PW = 5'b00010;
  localparam logic [4:0] PN = 5'b00100;
  localparam logic [4:0] PS = 5'b01000;
  localparam logic [4:0] PL = 5'b10000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'd0;
  logic [X_W-1:0]  my_x = '0;
  logic [Y_W-1:0]  my_y = '0;
  logic [HW-1:0]   hint = '0;
  logic            hd_valid = 1'b0;
  logic            hd_ready;
  logic [X_W-1:0]  hd_dst_x = '0;
  logic [Y_W-1:0]  hd_dst_y = '0;
  logic            route_valid;
  logic            route_ready = 1'b0;
  logic [4:0]      route_port;

  always #2.5 clk = ~clk;

  rc_turn_route #(.X_W(X_W), .Y_W(Y_W), .HINT_W(HINT_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .my_x        (my_x),
    .my_y        (my_y),
    .hint        (hint),
    .hd_valid    (hd_valid),
    .hd_ready    (hd_ready),
    .hd_dst_x    (hd_dst_x),
    .hd_dst_y    (hd_dst_y),
    .route_valid (route_valid),
    .route_ready (route_ready),
    .route_port  (route_port)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  mode;
    logic [3:0]  mx;
    logic [3:0]  my;
    logic [3:0]  dx;
    logic [3:0]  dy;
    logic [15:0] hint;
    logic [4:0]  exp;
  } vec_t;

  localparam int NV = 23;
  // hint nibbles from high to low: S, N, W, E
  localparam vec_t VECS [NV] = '{
    '{4'd6,  2'd0, 4'd3, 4'd3, 4'd5, 4'd1, 16'h0000, PE},
    '{4'd6,  2'd0, 4'd3, 4'd3, 4'd3, 4'd6, 16'h0000, PN},
    '{4'd6,  2'd0, 4'd3, 4'd3, 4'd1, 4'd5, 16'h0F00, PW},
    '{4'd6,  2'd0, 4'd3, 4'd3, 4'd3, 4'd0, 16'h0000, PS},
    '{4'd5,  2'd0, 4'd3, 4'd3, 4'd3, 4'd3, 16'h0000, PL},
    '{4'd7,  2'd1, 4'd3, 4'd3, 4'd1, 4'd6, 16'h0F00, PW},
    '{4'd11, 2'd1, 4'd3, 4'd3, 4'd5, 4'd6, 16'h0702, PN},
    '{4'd11, 2'd1, 4'd3, 4'd3, 4'd5, 4'd1, 16'h5005, PE},
    '{4'd7,  2'd1, 4'd3, 4'd3, 4'd3, 4'd1, 16'h0000, PS},
    '{4'd8,  2'd2, 4'd3, 4'd3, 4'd5, 4'd6, 16'h0F01, PE},
    '{4'd8,  2'd2, 4'd3, 4'd3, 4'd3, 4'd6, 16'h0000, PN},
    '{4'd11, 2'd2, 4'd3, 4'd3, 4'd1, 4'd1, 16'h6020, PS},
    '{4'd11, 2'd2, 4'd3, 4'd3, 4'd1, 4'd1, 16'h2060, PW},
    '{4'd9,  2'd3, 4'd3, 4'd3, 4'd1, 4'd6, 16'h0F10, PW},
    '{4'd9,  2'd3, 4'd3, 4'd3, 4'd5, 4'd1, 16'h100F, PS},
    '{4'd11, 2'd3, 4'd3, 4'd3, 4'd1, 4'd1, 16'h3030, PW},
    '{4'd11, 2'd3, 4'd3, 4'd3, 4'd5, 4'd6, 16'h0901, PN},
    '{4'd5,  2'd3, 4'd3, 4'd3, 4'd3, 4'd3, 16'hFFFF, PL},
    '{4'd5,  2'd1, 4'd3, 4'd3, 4'd3, 4'd3, 16'hFFFF, PL},
    '{4'd5,  2'd2, 4'd3, 4'd3, 4'd3, 4'd3, 16'hFFFF, PL},
    '{4'd10, 2'd0, 4'd0, 4'd0, 4'd15, 4'd15, 16'hFFFF, PE},
    '{4'd10, 2'd3, 4'd15, 4'd15, 4'd0, 4'd0, 16'h9010, PS},
    '{4'd10, 2'd1, 4'd0, 4'd15, 4'd15, 4'd0, 16'h8001, PS}
  };

  int total = 0;
  int bad   = 0;

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL R1: watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    check("R1", {31'd0, route_valid}, 32'd0);
    check("R1", {27'd0, route_port}, 32'd0);
    check("R1", {31'd0, hd_ready}, 32'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, route_valid}, 32'd0);
    check("R2", {27'd0, route_port}, 32'd0);
    check("R1", {31'd0, hd_ready}, 32'd1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      mode     = VECS[i].mode;
      my_x     = VECS[i].mx;
      my_y     = VECS[i].my;
      hd_dst_x = VECS[i].dx;
      hd_dst_y = VECS[i].dy;
      hint     = VECS[i].hint;
      hd_valid = 1'b1;
      @(negedge clk);
      hd_valid = 1'b0;
      check("R2", {31'd0, route_valid}, 32'd1);
      check(tag(VECS[i].req), {27'd0, route_port}, {27'd0, VECS[i].exp});
      route_ready = 1'b1;
      @(negedge clk);
      route_ready = 1'b0;
      check("R4", {31'd0, route_valid}, 32'd0);
      check("R2", {27'd0, route_port}, 32'd0);
    end

    // back-pressure and input sampling
    mode = 2'd2; my_x = 4'd3; my_y = 4'd3;
    hd_dst_x = 4'd1; hd_dst_y = 4'd1; hint = 16'h6020;
    hd_valid = 1'b1;
    @(negedge clk);
    check("R11", {27'd0, route_port}, {27'd0, PS});
    mode = 2'd0; hd_dst_x = 4'd5; hd_dst_y = 4'd6; hint = 16'h0F0F;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R3", {27'd0, route_port}, {27'd0, PS});
      check("R3", {31'd0, route_valid}, 32'd1);
      check("R3", {31'd0, hd_ready}, 32'd0);
    end
    route_ready = 1'b1;
    @(negedge clk);
    route_ready = 1'b0;
    check("R4", {31'd0, route_valid}, 32'd0);
    check("R4", {31'd0, hd_ready}, 32'd1);
    @(negedge clk);
    hd_valid = 1'b0;
    check("R12", {31'd0, route_valid}, 32'd1);
    check("R12", {27'd0, route_port}, {27'd0, PE});
    route_ready = 1'b1;
    @(negedge clk);
    route_ready = 1'b0;
    check("R4", {31'd0, route_valid}, 32'd0);

    // idle with no head offered
    repeat (3) @(negedge clk);
    check("R2", {27'd0, route_port}, 32'd0);
    check("R2", {31'd0, route_valid}, 32'd0);

    finish_run();
  end

endmodule